// File: doc/BRIEF.md
# Rate-Limit Resource Command Engine

This block provides indirect access to the ingress rate-limit resource storage of an Ethernet switch. Each port owns a set of resources, and each resource holds a few 16-bit registers. Software sees only two 16-bit registers on a simple register bus: a command register and a data register. To start an operation, the host writes a command word with its top bit set. The command names a port, a resource and a register. The engine then initialises the whole port, initialises one resource, writes one register from the data register, or reads one register into the data register.

The top bit of the command register stays set for as long as the engine is working. The host polls it until it reads clear before it issues the next command. The usual start-up sequence is one initialise-all command per port, which returns every resource of that port to its initial, limiting-disabled word value.

A parameter picks one of two incompatible opcode layouts. One layout has a 3-bit opcode that includes a no-op. The other has a 2-bit opcode in which the zero code means read. Because of this, one command value can mean quite different things in the two modes.

Top module: `rlc_engine`

## Requirements
- R1: After reset the command register and the data register both read 0x0000, and every storage word holds INIT_WORD.
- R2: The command register is at bus address 0x09 and the data register is at 0x0A. Reads return the current value in the same cycle. Any other address reads 0x0000, and writes to any other address change nothing.
- R3: A command write while idle with bit 15 set starts an operation. Bit 15 reads 1 until the operation ends and then clears. Bits 14:0 keep the written value. A command write with bit 15 clear is stored but starts nothing.
- R4: With NARROW_OP=0 the opcode is bits 14:12, coded 0 no-op, 1 init all, 2 init resource, 3 write, 4 read, and 5 to 7 act as no-op. The port is bits 11:8.
- R5: With NARROW_OP=1 the opcode is bits 14:13, coded 0 read, 1 init all, 2 init resource, 3 write. The port is bits 12:8. A command of 0x9000 reads port 16, resource 0, register 0 and clears nothing.
- R6: Init all writes INIT_WORD into all NUM_RES*NUM_REGS words of the port, one word per clock. Busy reads 1 for exactly that many cycles, and no other port changes.
- R7: Init resource writes INIT_WORD into the NUM_REGS words of the addressed resource only. Busy reads 1 for NUM_REGS cycles.
- R8: Write copies the data register into the addressed word. Busy reads 1 for one cycle.
- R9: Read loads the addressed word into the data register before busy clears. Busy reads 1 for one cycle. Outside of read operations, the data register changes only on a host write.
- R10: A no-op, or an operation whose port (0x00 to 0x1F), resource (bits 7:5) or register (bits 3:0) field is at or above the configured count, holds busy for one cycle. It leaves storage and the data register unchanged. Fields that the operation does not use are not checked.
- R11: While busy reads 1, host writes to the command register and to the data register are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| reg_wr | input | 1 | Register bus write strobe |
| reg_addr | input | 8 | Register bus address for reads and writes |
| reg_wdata | input | 16 | Register bus write data |
| reg_rdata | output | 16 | Register bus read data, combinational on reg_addr |

## Verification
The bench measures busy length in cycles for every operation kind. A walker that stops one word early, or runs one word long, shows up as a wrong count and as a stray or missing initial word in the full storage readback that follows each phase. It sends the word 0x9000 to both encodings: an engine that decodes the narrow field as the wide one would clear port 0 and not return the port-16 word. Out-of-range port, resource and register fields, reserved opcodes, and command or data writes while busy are each followed by a readback of the whole array and both registers, so a design that lets any of them through corrupts a visible word.

// File: rtl/rlc_pkg.sv
package rlc_pkg;

  localparam logic [7:0] CMD_OFS  = 8'h09;
  localparam logic [7:0] DATA_OFS = 8'h0A;
  localparam int         BUSY_BIT = 15;

  typedef enum logic [2:0] {
    OP_NOP      = 3'd0,
    OP_INIT_ALL = 3'd1,
    OP_INIT_RES = 3'd2,
    OP_WRITE    = 3'd3,
    OP_READ     = 3'd4
  } rlc_op_e;

  typedef struct packed {
    rlc_op_e    op;
    logic [4:0] port;
    logic [2:0] res;
    logic [3:0] regi;
  } rlc_cmd_t;

endpackage

// File: rtl/rlc_decode.sv
module rlc_decode
  import rlc_pkg::*;
#(
  parameter bit NARROW_OP = 1'b1
) (
  input  logic [15:0] cmd_word,
  output rlc_cmd_t    fields
);

  generate
    if (NARROW_OP) begin : g_two_bit
      always_comb begin
        fields.port = cmd_word[12:8];
        fields.res  = cmd_word[7:5];
        fields.regi = cmd_word[3:0];
        unique case (cmd_word[14:13])
          2'd0:    fields.op = OP_READ;
          2'd1:    fields.op = OP_INIT_ALL;
          2'd2:    fields.op = OP_INIT_RES;
          default: fields.op = OP_WRITE;
        endcase
      end
    end else begin : g_three_bit
      always_comb begin
        fields.port = {1'b0, cmd_word[11:8]};
        fields.res  = cmd_word[7:5];
        fields.regi = cmd_word[3:0];
        unique case (cmd_word[14:12])
          3'd1:    fields.op = OP_INIT_ALL;
          3'd2:    fields.op = OP_INIT_RES;
          3'd3:    fields.op = OP_WRITE;
          3'd4:    fields.op = OP_READ;
          default: fields.op = OP_NOP;
        endcase
      end
    end
  endgenerate

endmodule

// File: rtl/rlc_walker.sv
module rlc_walker #(
  parameter int MAX_LEN = 32,
  localparam int CW = $clog2(MAX_LEN + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [CW-1:0] len,
  output logic [CW-1:0] ofs,
  output logic          last
);

  logic [CW-1:0] ofs_q, ofs_d;

  assign last = (ofs_q == len - CW'(1));
  assign ofs  = ofs_q;

  always_comb begin
    ofs_d = ofs_q;
    if (run) begin
      ofs_d = last ? '0 : ofs_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ofs_q <= '0;
    end else if (run) begin
      ofs_q <= ofs_d;
    end
  end

endmodule

// File: rtl/rlc_store.sv
module rlc_store #(
  parameter int          WORDS     = 64,
  parameter int          AW        = 6,
  parameter logic [15:0] INIT_WORD = 16'h0000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [15:0]   wdata,
  input  logic [AW-1:0] raddr,
  output logic [15:0]   rdata
);

  logic [15:0] mem_q [WORDS];

  assign rdata = mem_q[raddr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < WORDS; i++) begin
        mem_q[i] <= INIT_WORD;
      end
    end else if (we) begin
      mem_q[waddr] <= wdata;
    end
  end

endmodule

// File: rtl/rlc_engine.sv
module rlc_engine
  import rlc_pkg::*;
#(
  parameter int          NUM_PORTS = 11,
  parameter int          NUM_RES   = 8,
  parameter int          NUM_REGS  = 4,
  parameter bit          NARROW_OP = 1'b1,
  parameter logic [15:0] INIT_WORD = 16'h0000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [7:0]  reg_addr,
  input  logic [15:0] reg_wdata,
  output logic [15:0] reg_rdata
);

  localparam int WORDS_PER_PORT = NUM_RES * NUM_REGS;
  localparam int WORDS          = NUM_PORTS * WORDS_PER_PORT;
  localparam int AW             = (WORDS > 1) ? $clog2(WORDS) : 1;
  localparam int CW             = $clog2(WORDS_PER_PORT + 1);

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_pipe_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= 2'b00;
    end else begin
      rst_pipe_q <= {rst_pipe_q[0], 1'b1};
    end
  end
  assign rst_sync_n = rst_pipe_q[1];

  // host-visible registers
  logic [15:0] cmd_q, cmd_d;
  logic [15:0] data_q, data_d;
  logic        busy;
  logic        sel_cmd, sel_data;
  logic        host_cmd_wr, host_data_wr;

  assign busy         = cmd_q[BUSY_BIT];
  assign sel_cmd      = (reg_addr == CMD_OFS);
  assign sel_data     = (reg_addr == DATA_OFS);
  assign host_cmd_wr  = reg_wr && sel_cmd && !busy;
  assign host_data_wr = reg_wr && sel_data && !busy;

  always_comb begin
    if (sel_cmd)       reg_rdata = cmd_q;
    else if (sel_data) reg_rdata = data_q;
    else               reg_rdata = 16'h0000;
  end

  // command decode
  rlc_cmd_t dec;

  rlc_decode #(.NARROW_OP(NARROW_OP)) u_dec (
    .cmd_word (cmd_q),
    .fields   (dec)
  );

  logic port_ok, res_ok, reg_ok, act;

  assign port_ok = (32'(dec.port) < 32'(NUM_PORTS));
  assign res_ok  = (32'(dec.res)  < 32'(NUM_RES));
  assign reg_ok  = (32'(dec.regi) < 32'(NUM_REGS));

  always_comb begin
    unique case (dec.op)
      OP_INIT_ALL:       act = port_ok;
      OP_INIT_RES:       act = port_ok && res_ok;
      OP_WRITE, OP_READ: act = port_ok && res_ok && reg_ok;
      default:           act = 1'b0;
    endcase
  end

  // word walker for the multi-cycle initialise operations
  logic [CW-1:0] walk_len, walk_ofs;
  logic          walk_last, run, finish;

  always_comb begin
    unique case (dec.op)
      OP_INIT_ALL: walk_len = CW'(WORDS_PER_PORT);
      OP_INIT_RES: walk_len = CW'(NUM_REGS);
      default:     walk_len = CW'(1);
    endcase
  end

  assign run    = busy && act;
  assign finish = busy && (!act || walk_last);

  rlc_walker #(.MAX_LEN(WORDS_PER_PORT)) u_walk (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .run   (run),
    .len   (walk_len),
    .ofs   (walk_ofs),
    .last  (walk_last)
  );

  // storage addressing
  logic [31:0]   port_base, res_base, base32;
  logic [AW-1:0] word_addr;
  logic          mem_we, load_rd;
  logic [15:0]   mem_wdata, mem_rdata;

  assign port_base = 32'(dec.port) * 32'(WORDS_PER_PORT);
  assign res_base  = port_base + 32'(dec.res) * 32'(NUM_REGS);

  always_comb begin
    unique case (dec.op)
      OP_INIT_ALL: base32 = port_base;
      OP_INIT_RES: base32 = res_base;
      default:     base32 = res_base + 32'(dec.regi);
    endcase
  end

  assign word_addr = AW'(base32 + 32'(walk_ofs));
  assign mem_we    = run && (dec.op == OP_INIT_ALL || dec.op == OP_INIT_RES ||
                             dec.op == OP_WRITE);
  assign mem_wdata = (dec.op == OP_WRITE) ? data_q : INIT_WORD;
  assign load_rd   = run && (dec.op == OP_READ);

  rlc_store #(.WORDS(WORDS), .AW(AW), .INIT_WORD(INIT_WORD)) u_store (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .we    (mem_we),
    .waddr (word_addr),
    .wdata (mem_wdata),
    .raddr (word_addr),
    .rdata (mem_rdata)
  );

  // next state of the host registers
  always_comb begin
    cmd_d = cmd_q;
    if (host_cmd_wr) begin
      cmd_d = reg_wdata;
    end else if (finish) begin
      cmd_d[BUSY_BIT] = 1'b0;
    end
  end

  always_comb begin
    data_d = data_q;
    if (host_data_wr) begin
      data_d = reg_wdata;
    end else if (load_rd) begin
      data_d = mem_rdata;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      cmd_q  <= 16'h0000;
      data_q <= 16'h0000;
    end else begin
      if (host_cmd_wr || finish) cmd_q  <= cmd_d;
      if (host_data_wr || load_rd) data_q <= data_d;
    end
  end

endmodule

// File: rtl/rlc_engine_chk.sv
module rlc_engine_chk
  import rlc_pkg::*;
#(
  parameter int MAX_RUN = 32
) (
  input logic        clk,
  input logic        rst_n,
  input logic        reg_wr,
  input logic [7:0]  reg_addr,
  input logic [15:0] reg_wdata,
  input logic [15:0] cmd_q,
  input logic [15:0] data_q,
  input logic        mem_we,
  input logic        load_rd
);

  logic [31:0] run_cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_cnt_q <= '0;
    end else if (cmd_q[BUSY_BIT]) begin
      run_cnt_q <= run_cnt_q + 32'd1;
    end else begin
      run_cnt_q <= '0;
    end
  end

  // R11: command fields are frozen while an operation runs
  assert_cmd_frozen_R11: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_q[BUSY_BIT] |=> $stable(cmd_q[14:0]));

  // R3: busy only rises from a host command write carrying bit 15
  assert_busy_source_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cmd_q[BUSY_BIT]) |-> $past(reg_wr && reg_addr == CMD_OFS && reg_wdata[BUSY_BIT]));

  // R9: when idle and not host-written, the data register holds
  assert_data_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd_q[BUSY_BIT] && !(reg_wr && reg_addr == DATA_OFS)) |=> $stable(data_q));

  // R9: a read operation ends on the cycle it loads data
  assert_read_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    load_rd |=> !cmd_q[BUSY_BIT]);

  // R10: storage is never written while idle
  assert_store_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> cmd_q[BUSY_BIT]);

  // R6: no operation holds busy longer than one full port walk
  assert_run_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    run_cnt_q <= 32'(MAX_RUN));

endmodule

bind rlc_engine rlc_engine_chk #(.MAX_RUN(WORDS_PER_PORT)) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .reg_wr    (reg_wr),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .cmd_q     (cmd_q),
  .data_q    (data_q),
  .mem_we    (mem_we),
  .load_rd   (load_rd)
);

// File: tb/rlc_engine_tb.sv
`timescale 1ns/1ps
module rlc_engine_tb;
  import rlc_pkg::*;

  localparam int NRES = 4;
  localparam int NREG = 4;
  localparam int WPP  = NRES * NREG;
  localparam int PA   = 17;
  localparam int PB   = 4;
  // narrow (2-bit) opcodes, instance u_dut
  localparam int A_RD = 0, A_IALL = 1, A_IRES = 2, A_WR = 3;
  // wide (3-bit) opcodes, instance u_dut_w3
  localparam int B_NOP = 0, B_IALL = 1, B_IRES = 2, B_WR = 3, B_RD = 4;

  logic        clk;
  logic        rst_n;
  logic        wr_a, wr_b;
  logic [7:0]  addr;
  logic [15:0] wdata;
  logic [15:0] rdata_a, rdata_b;

  initial clk = 1'b0;
  always #10 clk = ~clk;

  rlc_engine #(.NUM_PORTS(PA), .NUM_RES(NRES), .NUM_REGS(NREG),
               .NARROW_OP(1'b1), .INIT_WORD(16'h0000)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(wr_a), .reg_addr(addr),
    .reg_wdata(wdata), .reg_rdata(rdata_a));

  rlc_engine #(.NUM_PORTS(PB), .NUM_RES(NRES), .NUM_REGS(NREG),
               .NARROW_OP(1'b0), .INIT_WORD(16'h0000)) u_dut_w3 (
    .clk(clk), .rst_n(rst_n), .reg_wr(wr_b), .reg_addr(addr),
    .reg_wdata(wdata), .reg_rdata(rdata_b));

  int          n_cmp = 0;
  int          n_bad = 0;
  bit          done  = 1'b0;
  logic [15:0] mdl_a [PA*WPP];
  logic [15:0] mdl_b [PB*WPP];

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  // called at a negedge, returns at the next negedge
  task automatic bus_write(bit sel, logic [7:0] a, logic [15:0] d);
    addr  = a;
    wdata = d;
    if (sel) wr_b = 1'b1; else wr_a = 1'b1;
    @(negedge clk);
    wr_a = 1'b0;
    wr_b = 1'b0;
  endtask

  task automatic bus_read(bit sel, logic [7:0] a, output logic [15:0] v);
    addr = a;
    #1;
    v = sel ? rdata_b : rdata_a;
  endtask

  function automatic logic [15:0] mk_cmd(bit sel, int op, int p, int r, int g);
    if (sel) return {1'b1, 3'(op), 4'(p), 3'(r), 1'b0, 4'(g)};
    else     return {1'b1, 2'(op), 5'(p), 3'(r), 1'b0, 4'(g)};
  endfunction

  task automatic run_cmd(bit sel, logic [15:0] w, output int cyc);
    logic [15:0] v;
    bus_write(sel, CMD_OFS, w);
    bus_read(sel, CMD_OFS, v);
    cyc = 0;
    while (v[15] && cyc < 1000) begin
      @(negedge clk);
      cyc++;
      bus_read(sel, CMD_OFS, v);
    end
  endtask

  task automatic mdl_set(bit sel, int p, int r, int g, logic [15:0] v);
    if (sel) mdl_b[p*WPP + r*NREG + g] = v;
    else     mdl_a[p*WPP + r*NREG + g] = v;
  endtask

  task automatic write_word(bit sel, int p, int r, int g, logic [15:0] v);
    int cyc;
    bus_write(sel, DATA_OFS, v);
    run_cmd(sel, mk_cmd(sel, sel ? B_WR : A_WR, p, r, g), cyc);
    check("R8 write busy cycles", 16'(cyc), 16'd1);
    mdl_set(sel, p, r, g, v);
  endtask

  task automatic read_word(bit sel, int p, int r, int g, output logic [15:0] v);
    int cyc;
    run_cmd(sel, mk_cmd(sel, sel ? B_RD : A_RD, p, r, g), cyc);
    check("R9 read busy cycles", 16'(cyc), 16'd1);
    bus_read(sel, DATA_OFS, v);
  endtask

  task automatic sweep(bit sel, string tag);
    logic [15:0] v;
    for (int p = 0; p < (sel ? PB : PA); p++)
      for (int r = 0; r < NRES; r++)
        for (int g = 0; g < NREG; g++) begin
          read_word(sel, p, r, g, v);
          check(tag, v, sel ? mdl_b[p*WPP + r*NREG + g] : mdl_a[p*WPP + r*NREG + g]);
        end
  endtask

  task automatic clear_model(bit sel, int p, int r_lo, int r_hi);
    for (int r = r_lo; r <= r_hi; r++)
      for (int g = 0; g < NREG; g++) mdl_set(sel, p, r, g, 16'h0000);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: got %0d cycles expected completion", 150000);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] v, c0, d0, w;
    int cyc;
    rst_n = 1'b0; wr_a = 1'b0; wr_b = 1'b0; addr = 8'h00; wdata = 16'h0000;
    for (int i = 0; i < PA*WPP; i++) mdl_a[i] = 16'h0000;
    for (int i = 0; i < PB*WPP; i++) mdl_b[i] = 16'h0000;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state
    for (int s = 0; s < 2; s++) begin
      bus_read(1'(s), CMD_OFS, v);  check("R1 command after reset", v, 16'h0000);
      bus_read(1'(s), DATA_OFS, v); check("R1 data after reset", v, 16'h0000);
    end
    sweep(1'b0, "R1 storage after reset");
    sweep(1'b1, "R1 storage after reset");

    // R8/R9: fill every word with a distinct pattern and read it back
    for (int s = 0; s < 2; s++)
      for (int p = 0; p < (s != 0 ? PB : PA); p++)
        for (int r = 0; r < NRES; r++)
          for (int g = 0; g < NREG; g++)
            write_word(1'(s), p, r, g, 16'(16'h1000*(s+1) + p*256 + r*16 + g));
    sweep(1'b0, "R8 R9 pattern readback");
    sweep(1'b1, "R8 R9 pattern readback");

    // R5: 0x9000 on the narrow encoding reads port 16
    write_word(1'b0, 16, 0, 0, 16'hBEEF);
    run_cmd(1'b0, 16'h9000, cyc);
    check("R5 0x9000 busy cycles", 16'(cyc), 16'd1);
    bus_read(1'b0, DATA_OFS, v);
    check("R5 0x9000 read data", v, 16'hBEEF);
    sweep(1'b0, "R5 storage untouched");
    // R4: same word on the wide encoding is init all of port 0
    run_cmd(1'b1, 16'h9000, cyc);
    check("R4 0x9000 init-all cycles", 16'(cyc), 16'(WPP));
    clear_model(1'b1, 0, 0, NRES-1);
    sweep(1'b1, "R4 wide init-all of port 0");

    // R7: init one resource
    run_cmd(1'b0, mk_cmd(1'b0, A_IRES, 16, 2, 0), cyc);
    check("R7 init-res cycles", 16'(cyc), 16'(NREG));
    clear_model(1'b0, 16, 2, 2);
    run_cmd(1'b1, mk_cmd(1'b1, B_IRES, 3, 1, 0), cyc);
    check("R7 init-res cycles", 16'(cyc), 16'(NREG));
    clear_model(1'b1, 3, 1, 1);
    sweep(1'b0, "R7 storage after init-res");
    sweep(1'b1, "R7 storage after init-res");

    // R6: init all, including the first and last port
    run_cmd(1'b0, mk_cmd(1'b0, A_IALL, 0, 0, 0), cyc);
    check("R6 init-all cycles", 16'(cyc), 16'(WPP));
    clear_model(1'b0, 0, 0, NRES-1);
    w = mk_cmd(1'b0, A_IALL, 16, 3, 7);
    run_cmd(1'b0, w, cyc);
    check("R6 init-all last port cycles", 16'(cyc), 16'(WPP));
    clear_model(1'b0, 16, 0, NRES-1);
    bus_read(1'b0, CMD_OFS, v);
    check("R3 command bits kept, busy clear", v, w & 16'h7FFF);
    run_cmd(1'b1, mk_cmd(1'b1, B_IALL, 2, 0, 0), cyc);
    check("R6 init-all cycles", 16'(cyc), 16'(WPP));
    clear_model(1'b1, 2, 0, NRES-1);
    sweep(1'b0, "R6 storage after init-all");
    sweep(1'b1, "R6 storage after init-all");

    // R10: no-op, reserved codes and out-of-range fields
    bus_write(1'b1, DATA_OFS, 16'h5555);
    bus_write(1'b0, DATA_OFS, 16'h6666);
    for (int op = 0; op < 8; op++) begin
      if (op >= 1 && op <= 4) continue;
      run_cmd(1'b1, mk_cmd(1'b1, op, 1, 0, 0), cyc);
      check("R10 wide no-op cycles", 16'(cyc), 16'd1);
    end
    run_cmd(1'b1, mk_cmd(1'b1, B_WR, 5, 0, 0), cyc);
    check("R10 port out of range cycles", 16'(cyc), 16'd1);
    run_cmd(1'b1, mk_cmd(1'b1, B_RD, 7, 0, 0), cyc);
    check("R10 port out of range cycles", 16'(cyc), 16'd1);
    run_cmd(1'b1, mk_cmd(1'b1, B_IALL, 9, 0, 0), cyc);
    check("R10 port out of range cycles", 16'(cyc), 16'd1);
    run_cmd(1'b0, mk_cmd(1'b0, A_IALL, 20, 0, 0), cyc);
    check("R10 port out of range cycles", 16'(cyc), 16'd1);
    run_cmd(1'b0, mk_cmd(1'b0, A_IRES, 1, 5, 0), cyc);
    check("R10 resource out of range cycles", 16'(cyc), 16'd1);
    run_cmd(1'b0, mk_cmd(1'b0, A_WR, 1, 0, 9), cyc);
    check("R10 register out of range cycles", 16'(cyc), 16'd1);
    run_cmd(1'b0, mk_cmd(1'b0, A_RD, 1, 0, 9), cyc);
    check("R10 register out of range cycles", 16'(cyc), 16'd1);
    bus_read(1'b1, DATA_OFS, v); check("R10 data kept", v, 16'h5555);
    bus_read(1'b0, DATA_OFS, v); check("R10 data kept", v, 16'h6666);
    sweep(1'b0, "R10 storage unchanged");
    sweep(1'b1, "R10 storage unchanged");

    // R3: command write without busy bit starts nothing
    bus_write(1'b1, CMD_OFS, 16'h3123);
    bus_read(1'b1, CMD_OFS, v); check("R3 stored without busy", v, 16'h3123);
    @(negedge clk);
    bus_read(1'b1, CMD_OFS, v); check("R3 still idle", v, 16'h3123);
    sweep(1'b1, "R3 storage unchanged");

    // R11: writes while busy are ignored
    write_word(1'b1, 0, 0, 0, 16'hA5A5);
    bus_write(1'b1, DATA_OFS, 16'h1234);
    w = mk_cmd(1'b1, B_IALL, 1, 0, 0);
    bus_write(1'b1, CMD_OFS, w);
    bus_write(1'b1, CMD_OFS, mk_cmd(1'b1, B_WR, 0, 0, 0));
    bus_write(1'b1, DATA_OFS, 16'h7777);
    cyc = 2;
    bus_read(1'b1, CMD_OFS, v);
    while (v[15] && cyc < 1000) begin
      @(negedge clk);
      cyc++;
      bus_read(1'b1, CMD_OFS, v);
    end
    check("R11 busy cycles with blocked writes", 16'(cyc), 16'(WPP));
    check("R11 command unchanged", v, w & 16'h7FFF);
    bus_read(1'b1, DATA_OFS, v); check("R11 data unchanged", v, 16'h1234);
    clear_model(1'b1, 1, 0, NRES-1);
    sweep(1'b1, "R11 storage after blocked writes");

    // R2: unmapped addresses
    bus_read(1'b0, CMD_OFS, c0);
    bus_read(1'b0, DATA_OFS, d0);
    bus_read(1'b0, 8'h00, v); check("R2 unmapped read", v, 16'h0000);
    bus_read(1'b0, 8'h0B, v); check("R2 unmapped read", v, 16'h0000);
    bus_write(1'b0, 8'h0B, 16'hFFFF);
    bus_write(1'b0, 8'h08, 16'hFFFF);
    bus_read(1'b0, CMD_OFS, v);  check("R2 command untouched", v, c0);
    bus_read(1'b0, DATA_OFS, v); check("R2 data untouched", v, d0);
    sweep(1'b0, "R2 storage untouched");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule